// File: doc/BRIEF.md
# Windowed Register File Controller

This block keeps a physical array of general registers, 64 words of 32 bits by default, and shows software a sliding view of 16 of them. The view starts at a window base counted in groups of four registers. A bitmap holds one bit per four-register group and marks the groups that belong to live call frames.

The block carries out four windowed operations, each applied at one clock edge:
- **Call entry** checks the bitmap for frames that are still live ahead of the new frame. It then either moves the window up or requests a spill exception.
- **Windowed return** reads the caller's increment from the top two bits of visible register 0. It then either moves the window down or requests a fill exception.
- **Window rotate** moves the base by a signed amount.
- **Stack-pointer move** checks that some caller frame lies directly below the current one.

Exceptions and return results are registered outputs. They are valid for one cycle after the edge that accepts the operation. The spill and fill handler software lies outside the block.

Top module: `winreg_ctrl`

## Requirements
- R1: After reset the window base is 0, the start bitmap is 0x0001 (only group 0 live), and both `excReq` and `retValid` are low.
- R2: Visible register r maps to physical register (base*4 + r) mod NAREG, so a window may wrap past the end of the array. `rdData` is a combinational read of visible register `rdAddr`. The external write port writes visible register `extAddr` only when `opCode` is NOP (0). When any other operation is presented, the external write has no effect.
- R3: A call entry (`opCode` 1) is illegal when `regSel` > 3, when `ovfEnable` is 0, or when `excMode` is 1. An illegal call entry raises vector 1. Base, bitmap and registers stay unchanged.
- R4: A legal call entry raises a spill only when a bitmap bit is set among the `callInc` groups that directly follow the base, with the groups counted circularly. Groups further ahead are ignored.
- R5: The spill size comes from the trailing-zero count of the rotated bitmap beyond the first set bit among those groups. A count of 0 gives vector 3 (spill 4), 1 gives vector 4 (spill 8), and any other count gives vector 5 (spill 12). The base then advances by the distance to that first set bit. `excOldBase` records the previous base, and the bitmap stays unchanged.
- R6: A call entry without a spill writes visible register `callInc*4 + regSel` with the value of visible register `regSel` minus `immVal`. It then advances the base by `callInc` and sets the new base's bitmap bit.
- R7: A return (`opCode` 2) takes n from bits 31:30 of visible register 0 and m as the distance (1, 2 or 3) to the nearest live group below the base, with m = 0 when there is none. The return is illegal (vector 1) when n = 0, when m is nonzero and not equal to n, when `ovfEnable` is 0, or when `excMode` is 1.
- R8: A legal return moves the base down by n. If the new base's group is live, the old base's bit is cleared, `retValid` pulses, and `retPc` = {`pcIn`[31:30], register 0 [29:0]}.
- R9: If the group at the new base is not live, the return raises vector 6, 7 or 8 (fill 4, 8 or 12) for n = 1, 2 or 3. The base still moves, the bitmap stays unchanged, `excOldBase` holds the old base, and `excPc` holds `pcIn`.
- R10: A stack-pointer move (`opCode` 4) raises vector 2 when none of the three groups directly below the base is live. Otherwise it raises nothing.
- R11: A rotate (`opCode` 3) adds the signed 4-bit value `immVal`[3:0] to the base modulo NAREG/4. It leaves the bitmap unchanged.
- R12: `excReq` and `retValid` are one-cycle pulses after the accepting edge and are never high together. `excPc` captures `pcIn` for every exception. The bitmap is never all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opCode | input | 3 | 0 NOP, 1 call entry, 2 return, 3 rotate, 4 stack-pointer move |
| regSel | input | 4 | Stack register specifier for call entry |
| callInc | input | 2 | Call increment from status |
| immVal | input | DW | Frame size for call entry; bits 3:0 give the rotate amount |
| pcIn | input | DW | Program counter of the operation |
| ovfEnable | input | 1 | Window overflow enable status bit |
| excMode | input | 1 | Exception mode status bit |
| extWrEn | input | 1 | External visible-register write strobe |
| extAddr | input | 4 | External write visible index |
| extData | input | DW | External write data |
| rdAddr | input | 4 | Read visible index |
| rdData | output | DW | Read data |
| winBase | output | WBW | Current window base |
| winStart | output | NGRP | Live-group bitmap |
| excReq | output | 1 | Exception request pulse |
| excVec | output | 4 | Exception vector code |
| excOldBase | output | WBW | Base before the excepting operation |
| excPc | output | DW | PC saved at the exception |
| retValid | output | 1 | Clean return pulse |
| retPc | output | DW | Return target |

## Verification
Some properties are checked on every cycle:
- the bitmap never empties, and return and exception never coincide;
- a rotate never touches the bitmap;
- a spill or fill leaves the bitmap unchanged, and a spill always moves the base;
- an out-of-range stack specifier always yields an illegal-instruction request with the state frozen.

Other behaviour needs scenarios that build a specific bitmap first: the choice among spill 4, 8 or 12, the m-versus-n comparison on return, the mapping of a window across the end of the array, and the register value left by a call entry. The bench shows these by comparing outputs against hand-derived values.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_CALLENTRY = 3'd1,
    OP_WRET      = 3'd2,
    OP_ROTATE    = 3'd3,
    OP_SPMOVE    = 3'd4
  } winOp_e;

  typedef enum logic [3:0] {
    EXC_NONE    = 4'd0,
    EXC_ILLEGAL = 4'd1,
    EXC_ALLOCA  = 4'd2,
    EXC_SPILL4  = 4'd3,
    EXC_SPILL8  = 4'd4,
    EXC_SPILL12 = 4'd5,
    EXC_FILL4   = 4'd6,
    EXC_FILL8   = 4'd7,
    EXC_FILL12  = 4'd8
  } winExc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic extWr;    // external write through the window
    logic entryWr;  // call-entry frame pointer write
  } dpStrobe_t;

endpackage

// File: rtl/winreg_dp.sv
module winreg_dp
  import winreg_pkg::*;
#(
  parameter int NAREG = 64,
  parameter int DW    = 32,
  localparam int NGRP = NAREG / 4,
  localparam int WBW  = $clog2(NGRP),
  localparam int PAW  = $clog2(NAREG)
) (
  input  logic            clk,
  input  dpStrobe_t       strobe,
  input  logic [WBW-1:0]  winBase,
  input  logic [1:0]      callInc,
  input  logic [3:0]      regSel,
  input  logic [DW-1:0]   immVal,
  input  logic [3:0]      extAddr,
  input  logic [DW-1:0]   extData,
  input  logic [3:0]      rdAddr,
  output logic [DW-1:0]   rdData,
  output logic [DW-1:0]   a0Data
);

  logic [DW-1:0] physReg [NAREG];

  // visible index to physical index, modulo the power-of-two array size
  function automatic logic [PAW-1:0] toPhys(input logic [WBW-1:0] b,
                                            input logic [3:0] r);
    return PAW'({b, 2'b00}) + PAW'(r);
  endfunction

  logic [DW-1:0]  sData;
  logic [PAW-1:0] wrIdx;
  logic [DW-1:0]  wrVal;
  logic           wrEn;

  assign rdData = physReg[toPhys(winBase, rdAddr)];
  assign a0Data = physReg[toPhys(winBase, 4'd0)];
  assign sData  = physReg[toPhys(winBase, regSel)];

  always_comb begin
    wrEn  = strobe.entryWr | strobe.extWr;
    wrIdx = toPhys(winBase, extAddr);
    wrVal = extData;
    if (strobe.entryWr) begin
      wrIdx = toPhys(winBase, {callInc, regSel[1:0]});
      wrVal = sData - immVal;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) physReg[wrIdx] <= wrVal;
  end

endmodule

// File: rtl/winreg_ctl.sv
module winreg_ctl
  import winreg_pkg::*;
#(
  parameter int NAREG = 64,
  parameter int DW    = 32,
  localparam int NGRP = NAREG / 4,
  localparam int WBW  = $clog2(NGRP)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [2:0]      opCode,
  input  logic [3:0]      regSel,
  input  logic [1:0]      callInc,
  input  logic [3:0]      rotAmt,
  input  logic [DW-1:0]   pcIn,
  input  logic            ovfEnable,
  input  logic            excMode,
  input  logic            extWrEn,
  input  logic [DW-1:0]   a0Data,
  output dpStrobe_t       strobe,
  output logic [WBW-1:0]  winBase,
  output logic [NGRP-1:0] winStart,
  output logic            excReq,
  output logic [3:0]      excVec,
  output logic [WBW-1:0]  excOldBase,
  output logic [DW-1:0]   excPc,
  output logic            retValid,
  output logic [DW-1:0]   retPc
);

  // trailing-zero count; NGRP when the vector is empty
  function automatic logic [WBW:0] ctzG(input logic [NGRP-1:0] v);
    logic [WBW:0] r;
    r = (WBW+1)'(NGRP);
    for (int i = NGRP - 1; i >= 0; i--) begin
      if (v[i]) r = (WBW+1)'(i);
    end
    return r;
  endfunction

  winOp_e         op;
  logic [NGRP-1:0] wsRot, incMask, remBits;
  logic [WBW:0]   firstSet, spillN, remTz, spillSum;
  logic           entryBad, spillHit;
  logic [WBW-1:0] entryBase, spillBase, retBase, rotBase;
  logic [WBW+3:0] rotSum;
  logic [WBW-1:0] below1, below2, below3;
  logic [1:0]     retN, retM;
  logic           retBad, anyBelow;

  logic [WBW-1:0]  nBase;
  logic [NGRP-1:0] nStart;
  logic            fire, retOk;
  winExc_e         vec;

  assign op = winOp_e'(opCode);

  // bitmap viewed from the group after the base
  always_comb begin
    for (int j = 0; j < NGRP; j++) begin
      wsRot[j] = winStart[WBW'(winBase + WBW'(1) + WBW'(j))];
    end
  end

  assign incMask   = (NGRP'(1) << callInc) - NGRP'(1);
  assign spillHit  = |(wsRot & incMask);
  assign firstSet  = ctzG(wsRot);
  assign spillN    = firstSet + (WBW+1)'(1);
  assign remBits   = wsRot >> spillN;
  assign remTz     = ctzG(remBits);
  assign spillSum  = {1'b0, winBase} + spillN;
  assign spillBase = spillSum[WBW-1:0];
  assign entryBad  = (regSel > 4'd3) || !ovfEnable || excMode;
  assign entryBase = winBase + WBW'(callInc);

  assign below1   = winBase - WBW'(1);
  assign below2   = winBase - WBW'(2);
  assign below3   = winBase - WBW'(3);
  assign anyBelow = winStart[below1] | winStart[below2] | winStart[below3];

  always_comb begin
    if (winStart[below1])      retM = 2'd1;
    else if (winStart[below2]) retM = 2'd2;
    else if (winStart[below3]) retM = 2'd3;
    else                       retM = 2'd0;
  end

  assign retN    = a0Data[DW-1:DW-2];
  assign retBad  = (retN == 2'd0) || ((retM != 2'd0) && (retM != retN)) ||
                   !ovfEnable || excMode;
  assign retBase = winBase - WBW'(retN);

  assign rotSum  = {{WBW{rotAmt[3]}}, rotAmt} + (WBW+4)'(winBase);
  assign rotBase = rotSum[WBW-1:0];

  always_comb begin
    nBase          = winBase;
    nStart         = winStart;
    fire           = 1'b0;
    retOk          = 1'b0;
    vec            = EXC_NONE;
    strobe.entryWr = 1'b0;
    strobe.extWr   = (op == OP_NOP) && extWrEn;
    case (op)
      OP_CALLENTRY: begin
        if (entryBad) begin
          fire = 1'b1;
          vec  = EXC_ILLEGAL;
        end else if (spillHit) begin
          fire  = 1'b1;
          nBase = spillBase;
          if (remTz == '0)                  vec = EXC_SPILL4;
          else if (remTz == (WBW+1)'(1))    vec = EXC_SPILL8;
          else                              vec = EXC_SPILL12;
        end else begin
          strobe.entryWr = 1'b1;
          nBase          = entryBase;
          nStart         = winStart | (NGRP'(1) << entryBase);
        end
      end
      OP_WRET: begin
        if (retBad) begin
          fire = 1'b1;
          vec  = EXC_ILLEGAL;
        end else begin
          nBase = retBase;
          if (winStart[retBase]) begin
            retOk  = 1'b1;
            nStart = winStart & ~(NGRP'(1) << winBase);
          end else begin
            fire = 1'b1;
            case (retN)
              2'd1:    vec = EXC_FILL4;
              2'd2:    vec = EXC_FILL8;
              default: vec = EXC_FILL12;
            endcase
          end
        end
      end
      OP_ROTATE: nBase = rotBase;
      OP_SPMOVE: begin
        if (!anyBelow) begin
          fire = 1'b1;
          vec  = EXC_ALLOCA;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winBase    <= '0;
      winStart   <= NGRP'(1);
      excReq     <= 1'b0;
      excVec     <= EXC_NONE;
      excOldBase <= '0;
      excPc      <= '0;
      retValid   <= 1'b0;
      retPc      <= '0;
    end else begin
      winBase  <= nBase;
      winStart <= nStart;
      excReq   <= fire;
      excVec   <= vec;
      retValid <= retOk;
      if (fire) begin
        excOldBase <= winBase;
        excPc      <= pcIn;
      end
      if (retOk) retPc <= {pcIn[DW-1:DW-2], a0Data[DW-3:0]};
    end
  end

endmodule

// File: rtl/winreg_ctrl.sv
module winreg_ctrl
  import winreg_pkg::*;
#(
  parameter int NAREG = 64,
  parameter int DW    = 32,
  localparam int NGRP = NAREG / 4,
  localparam int WBW  = $clog2(NGRP)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [2:0]      opCode,
  input  logic [3:0]      regSel,
  input  logic [1:0]      callInc,
  input  logic [DW-1:0]   immVal,
  input  logic [DW-1:0]   pcIn,
  input  logic            ovfEnable,
  input  logic            excMode,
  input  logic            extWrEn,
  input  logic [3:0]      extAddr,
  input  logic [DW-1:0]   extData,
  input  logic [3:0]      rdAddr,
  output logic [DW-1:0]   rdData,
  output logic [WBW-1:0]  winBase,
  output logic [NGRP-1:0] winStart,
  output logic            excReq,
  output logic [3:0]      excVec,
  output logic [WBW-1:0]  excOldBase,
  output logic [DW-1:0]   excPc,
  output logic            retValid,
  output logic [DW-1:0]   retPc
);

  dpStrobe_t     strobe;
  logic [DW-1:0] a0Data;

  winreg_ctl #(.NAREG(NAREG), .DW(DW)) ctl_i (
    .clk(clk), .rstN(rstN), .opCode(opCode), .regSel(regSel),
    .callInc(callInc), .rotAmt(immVal[3:0]), .pcIn(pcIn),
    .ovfEnable(ovfEnable), .excMode(excMode), .extWrEn(extWrEn),
    .a0Data(a0Data), .strobe(strobe), .winBase(winBase),
    .winStart(winStart), .excReq(excReq), .excVec(excVec),
    .excOldBase(excOldBase), .excPc(excPc), .retValid(retValid),
    .retPc(retPc)
  );

  winreg_dp #(.NAREG(NAREG), .DW(DW)) dp_i (
    .clk(clk), .strobe(strobe), .winBase(winBase), .callInc(callInc),
    .regSel(regSel), .immVal(immVal), .extAddr(extAddr),
    .extData(extData), .rdAddr(rdAddr), .rdData(rdData),
    .a0Data(a0Data)
  );

endmodule

// File: rtl/winreg_chk.sv
module winreg_chk #(
  parameter int NAREG = 64,
  localparam int NGRP = NAREG / 4,
  localparam int WBW  = $clog2(NGRP)
) (
  input logic            clk,
  input logic            rstN,
  input logic [2:0]      opCode,
  input logic [3:0]      regSel,
  input logic [WBW-1:0]  winBase,
  input logic [NGRP-1:0] winStart,
  input logic            excReq,
  input logic [3:0]      excVec,
  input logic [WBW-1:0]  excOldBase,
  input logic            retValid
);

  // R12
  excl_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(excReq && retValid));

  // R12
  live_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    winStart != '0);

  // R11
  rotate_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd3) |=> $stable(winStart));

  // R3
  bad_spec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd1 && regSel > 4'd3) |=>
      (excReq && excVec == 4'd1 && $stable(winBase) && $stable(winStart)));

  // R5
  spill_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && excVec >= 4'd3 && excVec <= 4'd5) |->
      ($stable(winStart) && winBase != excOldBase));

  // R9
  fill_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && excVec >= 4'd6) |-> $stable(winStart));

  // R10
  spmove_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd4) |=> (!retValid && (!excReq || excVec == 4'd2)));

endmodule

bind winreg_ctrl winreg_chk #(.NAREG(NAREG)) chk_i (
  .clk(clk), .rstN(rstN), .opCode(opCode), .regSel(regSel),
  .winBase(winBase), .winStart(winStart), .excReq(excReq),
  .excVec(excVec), .excOldBase(excOldBase), .retValid(retValid)
);

// File: tb/winreg_ctrl_tb.sv
module winreg_ctrl_tb_top;
  import winreg_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic [3:0]  regSel = '0;
  logic [1:0]  callInc = '0;
  logic [31:0] immVal = '0;
  logic [31:0] pcIn = '0;
  logic        ovfEnable = 1'b1;
  logic        excMode = 1'b0;
  logic        extWrEn = 1'b0;
  logic [3:0]  extAddr = '0;
  logic [31:0] extData = '0;
  logic [3:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [3:0]  winBase;
  logic [15:0] winStart;
  logic        excReq;
  logic [3:0]  excVec;
  logic [3:0]  excOldBase;
  logic [31:0] excPc;
  logic        retValid;
  logic [31:0] retPc;

  winreg_ctrl dut_i (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    string       tag;
    bit          e;
    logic [3:0]  v;
    int          b;
    int          ws;
    bit          rv;
    logic [31:0] rpc;
    int          owb;
    logic [31:0] epc;
  } expItem_t;

  expItem_t expQ[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: compares registered results at the due negedge
  always @(negedge clk) begin
    if (expQ.size() > 0 && expQ[0].due == cyc) begin
      expItem_t it;
      it = expQ.pop_front();
      chk(excReq == it.e, it.tag, "excReq", 32'(excReq), 32'(it.e));
      chk(excVec == it.v, it.tag, "excVec", 32'(excVec), 32'(it.v));
      chk(winBase == 4'(it.b), it.tag, "winBase", 32'(winBase), 32'(it.b));
      chk(winStart == 16'(it.ws), it.tag, "winStart", 32'(winStart), 32'(it.ws));
      chk(retValid == it.rv, it.tag, "retValid", 32'(retValid), 32'(it.rv));
      if (it.rv) chk(retPc == it.rpc, it.tag, "retPc", retPc, it.rpc);
      if (it.e) chk(excPc == it.epc, it.tag, "excPc", excPc, it.epc);
      if (it.owb >= 0)
        chk(excOldBase == 4'(it.owb), it.tag, "excOldBase", 32'(excOldBase), 32'(it.owb));
    end
  end

  // driver: applies an operation and pushes its expected outcome
  task automatic runOp(input logic [2:0] op, input logic [3:0] s,
                       input logic [1:0] ci, input logic [31:0] imm,
                       input logic [31:0] pc, input bit ovf, input bit em,
                       input string tag, input bit e, input logic [3:0] v,
                       input int b, input int ws, input bit rv,
                       input logic [31:0] rpc, input int owb);
    expItem_t it;
    opCode = op; regSel = s; callInc = ci; immVal = imm; pcIn = pc;
    ovfEnable = ovf; excMode = em;
    it.due = cyc + 1; it.tag = tag; it.e = e; it.v = v; it.b = b;
    it.ws = ws; it.rv = rv; it.rpc = rpc; it.owb = owb; it.epc = pc;
    expQ.push_back(it);
    @(negedge clk);
    opCode = 3'd0; extWrEn = 1'b0; ovfEnable = 1'b1; excMode = 1'b0;
  endtask

  task automatic extWrite(input logic [3:0] a, input logic [31:0] d);
    extWrEn = 1'b1; extAddr = a; extData = d;
    @(negedge clk);
    extWrEn = 1'b0;
  endtask

  task automatic readCheck(input logic [3:0] a, input logic [31:0] exp,
                           input string tag);
    rdAddr = a;
    #1;
    chk(rdData == exp, tag, "rdData", rdData, exp);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    chk(winBase == 4'd0, "R1", "winBase", 32'(winBase), 0);
    chk(winStart == 16'h0001, "R1", "winStart", 32'(winStart), 1);
    chk(!excReq && !retValid, "R1", "pulses", 32'({excReq, retValid}), 0);

    // R2 mapping and write gating
    extWrite(4'd1, 32'h1000);
    extWrite(4'd3, 32'h1111);
    readCheck(4'd1, 32'h1000, "R2");
    extWrEn = 1'b1; extAddr = 4'd3; extData = 32'hDEAD;
    runOp(3'd3, 0, 0, 32'h0, 0, 1, 0, "R11 rot0", 0, 0, 0, 16'h0001, 0, 0, -1);
    readCheck(4'd3, 32'h1111, "R2 ignored write");

    // R6 successful entry
    runOp(3'd1, 4'd1, 2'd1, 32'h10, 32'h100, 1, 0, "R6", 0, 0, 1, 16'h0003, 0, 0, -1);
    readCheck(4'd1, 32'h0FF0, "R6 frame value");

    // R3 illegal entries
    runOp(3'd1, 4'd4, 2'd1, 0, 32'h104, 1, 0, "R3 spec", 1, 1, 1, 16'h0003, 0, 0, -1);
    runOp(3'd1, 4'd1, 2'd1, 0, 32'h108, 0, 0, "R3 ovfen", 1, 1, 1, 16'h0003, 0, 0, -1);
    runOp(3'd1, 4'd1, 2'd1, 0, 32'h10C, 1, 1, "R3 excmode", 1, 1, 1, 16'h0003, 0, 0, -1);

    // R11 rotate with wrap
    runOp(3'd3, 0, 0, 32'hE, 0, 1, 0, "R11 minus2", 0, 0, 15, 16'h0003, 0, 0, -1);
    runOp(3'd3, 0, 0, 32'h2, 0, 1, 0, "R11 plus2", 0, 0, 1, 16'h0003, 0, 0, -1);

    // R2 window wrapping past array end
    runOp(3'd3, 0, 0, 32'hE, 0, 1, 0, "R11 to15", 0, 0, 15, 16'h0003, 0, 0, -1);
    extWrite(4'd5, 32'hABCD);
    runOp(3'd3, 0, 0, 32'h1, 0, 1, 0, "R11 to0", 0, 0, 0, 16'h0003, 0, 0, -1);
    readCheck(4'd1, 32'hABCD, "R2 wrap");

    // R4 only callInc groups matter; R5 spill4 with wrap
    runOp(3'd3, 0, 0, 32'hE, 0, 1, 0, "R11 to14", 0, 0, 14, 16'h0003, 0, 0, -1);
    runOp(3'd1, 4'd0, 2'd1, 0, 32'h200, 1, 0, "R4 no spill", 0, 0, 15, 16'h8003, 0, 0, -1);
    runOp(3'd1, 4'd0, 2'd1, 0, 32'h204, 1, 0, "R5 spill4", 1, 3, 0, 16'h8003, 0, 0, 15);

    // R5 spill8
    doReset();
    runOp(3'd1, 4'd1, 2'd2, 0, 0, 1, 0, "R6 ci2", 0, 0, 2, 16'h0005, 0, 0, -1);
    runOp(3'd3, 0, 0, 32'hC, 0, 1, 0, "R11 minus4", 0, 0, 14, 16'h0005, 0, 0, -1);
    runOp(3'd1, 4'd1, 2'd3, 0, 32'h300, 1, 0, "R5 spill8", 1, 4, 0, 16'h0005, 0, 0, 14);

    // R5 spill12
    doReset();
    runOp(3'd1, 4'd1, 2'd3, 0, 0, 1, 0, "R6 ci3", 0, 0, 3, 16'h0009, 0, 0, -1);
    runOp(3'd3, 0, 0, 32'hB, 0, 1, 0, "R11 minus5", 0, 0, 14, 16'h0009, 0, 0, -1);
    runOp(3'd1, 4'd1, 2'd3, 0, 32'h400, 1, 0, "R5 spill12", 1, 5, 0, 16'h0009, 0, 0, 14);

    // R8 clean return
    doReset();
    runOp(3'd1, 4'd1, 2'd1, 0, 0, 1, 0, "R6 ci1", 0, 0, 1, 16'h0003, 0, 0, -1);
    extWrite(4'd0, 32'h4000_0100);
    runOp(3'd2, 0, 0, 0, 32'h8000_0000, 1, 0, "R8 ret", 0, 0, 0, 16'h0001, 1, 32'h8000_0100, -1);

    // R7 illegal returns, R10 stack move
    doReset();
    runOp(3'd1, 4'd1, 2'd2, 0, 0, 1, 0, "R6 ci2b", 0, 0, 2, 16'h0005, 0, 0, -1);
    runOp(3'd4, 0, 0, 0, 32'h500, 1, 0, "R10 live", 0, 0, 2, 16'h0005, 0, 0, -1);
    extWrite(4'd0, 32'h4000_0010);
    runOp(3'd2, 0, 0, 0, 32'h504, 1, 0, "R7 m!=n", 1, 1, 2, 16'h0005, 0, 0, -1);
    extWrite(4'd0, 32'h0000_0010);
    runOp(3'd2, 0, 0, 0, 32'h508, 1, 0, "R7 n0", 1, 1, 2, 16'h0005, 0, 0, -1);
    extWrite(4'd0, 32'h8000_0010);
    runOp(3'd2, 0, 0, 0, 32'h50C, 0, 0, "R7 ovfen", 1, 1, 2, 16'h0005, 0, 0, -1);
    runOp(3'd2, 0, 0, 0, 32'h510, 1, 1, "R7 excmode", 1, 1, 2, 16'h0005, 0, 0, -1);
    runOp(3'd2, 0, 0, 0, 32'h1234, 1, 0, "R8 ret2", 0, 0, 0, 16'h0001, 1, 32'h0000_0010, -1);
    runOp(3'd4, 0, 0, 0, 32'h600, 1, 0, "R10 alloca", 1, 2, 0, 16'h0001, 0, 0, -1);

    // R9 fills
    doReset();
    runOp(3'd1, 4'd1, 2'd2, 0, 0, 1, 0, "R6 ci2c", 0, 0, 2, 16'h0005, 0, 0, -1);
    runOp(3'd3, 0, 0, 32'h6, 0, 1, 0, "R11 plus6", 0, 0, 8, 16'h0005, 0, 0, -1);
    runOp(3'd4, 0, 0, 0, 32'h700, 1, 0, "R10 alloca2", 1, 2, 8, 16'h0005, 0, 0, -1);
    extWrite(4'd0, 32'hC000_0020);
    runOp(3'd2, 0, 0, 0, 32'h4000_0004, 1, 0, "R9 fill12", 1, 8, 5, 16'h0005, 0, 0, 8);
    runOp(3'd3, 0, 0, 32'h3, 0, 1, 0, "R11 plus3", 0, 0, 8, 16'h0005, 0, 0, -1);
    extWrite(4'd0, 32'h4000_0020);
    runOp(3'd2, 0, 0, 0, 32'h4000_0008, 1, 0, "R9 fill4", 1, 6, 7, 16'h0005, 0, 0, 8);
    runOp(3'd3, 0, 0, 32'h1, 0, 1, 0, "R11 plus1", 0, 0, 8, 16'h0005, 0, 0, -1);
    extWrite(4'd0, 32'h8000_0020);
    runOp(3'd2, 0, 0, 0, 32'h4000_000C, 1, 0, "R9 fill8", 1, 7, 6, 16'h0005, 0, 0, 8);

    repeat (2) @(negedge clk);
    chk(expQ.size() == 0, "R12", "pending items", 32'(expQ.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule